// File: doc/BRIEF.md
# Baseband Power-Up Reset Sequencer

This block takes a baseband subsystem from power-off to a released reset. Any one of four wake events starts it: the power key pulled low, a charger connection, a battery insertion, or a real-time-clock alarm. It waits out a first delay and then enters its reset phase. In that phase it waits until the battery comparator reports a voltage above cut-off, lets the references settle, and turns on the flash supply. A short gap later it turns on the four core-side supplies together. It then holds the active-low baseband reset for a final interval and releases it.

All timing is counted in strobes of a free-running microsecond tick input. The default parameters give 20 ms, 200 ms, 500 us and 20 ms stages. A watchdog starts when the reset phase begins and runs with its longest period. It is acknowledged by the block itself on the rising edge of the reset output. After that it runs with a shorter period and software restarts it through an acknowledge input. Whenever the watchdog expires, the block drops every output and returns to power-off.

The oscillator supply is forced on for the whole reset phase. Once the reset is released, that supply follows the sleep control input. The event that caused the start is latched into a status register. The supply of the subscriber card is not part of the sequence and has no output here.

Top module: `pwrup_seq_top`

## Requirements
- R1: While the synchronous reset is asserted, and after it is released with no wake event, every regulator enable, `oscRegEn`, `bbResetN`, `relIrq` and `wakeSrc` are 0.
- R2: In power-off, a wake event starts the sequence on the next clock edge. The events are `pwrKeyN` low, `chargerIn` high, `battInsert` high and `rtcAlarm` high. At that edge, all events present are latched into `wakeSrc`, replacing the old value: bit 0 is the power key, bit 1 the charger, bit 2 the battery insertion and bit 3 the alarm.
- R3: For the first `WAKE_US` ticks after the start, no regulator enable and no `oscRegEn` is asserted.
- R4: When the wake delay ends, settling starts at once if `battOk` is 1. Otherwise the block waits, with no regulator on, until `battOk` is 1. `regFlashEn` rises on the `SETTLE_US`-th tick of settling.
- R5: All four bits of `regMainEn` rise together on the `GAP_US`-th tick after `regFlashEn` rises, and `regFlashEn` stays on.
- R6: `bbResetN` stays low for `HOLD_US` ticks after the main enables rise and then goes high. `relIrq` is a one-cycle pulse in the first cycle that `bbResetN` is high.
- R7: `oscRegEn` is 1 from the end of the wake delay until the reset is released, whatever `sleepN` is. After release it equals `sleepN`. It is 0 in power-off and during the wake delay.
- R8: The watchdog starts counting ticks at the end of the wake delay, with limit `WDOG_LONG_US`. If the count reaches the limit before release, all outputs except `wakeSrc` return to 0 (power-off).
- R9: At reset release the watchdog count restarts and then uses limit `WDOG_RUN_US`. A `wdAck` pulse after release restarts the count. Expiry returns the block to power-off.
- R10: Wake events that occur while a sequence is in progress or after release do not change `wakeSrc` and do not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Synchronous reset, active low |
| tickUs | input | 1 | One-cycle time-base strobe, one per microsecond |
| pwrKeyN | input | 1 | Power key, active low |
| chargerIn | input | 1 | Charger connected |
| battInsert | input | 1 | Battery insertion event |
| rtcAlarm | input | 1 | Real-time-clock alarm |
| battOk | input | 1 | Battery above cut-off high threshold |
| sleepN | input | 1 | Sleep control, 0 = sleep requested |
| wdAck | input | 1 | Software watchdog acknowledge strobe |
| regFlashEn | output | 1 | Flash supply enable |
| regMainEn | output | 4 | Auxiliary, analog, I/O and core supply enables (bits 0..3) |
| oscRegEn | output | 1 | Oscillator supply enable |
| bbResetN | output | 1 | Baseband reset, active low |
| wakeSrc | output | 4 | Latched wake cause |
| relIrq | output | 1 | One-cycle pulse at reset release |

## Verification
A start is due one clock edge after the event is sampled. Every later stage boundary falls on the edge that takes the Nth tick of that stage, and the outputs decode directly from the state register. The bench therefore raises `tickUs` for exactly one cycle per tick and samples on the following falling edge. It can then check each output one tick before and exactly on the boundary tick. Watchdog expiry is checked the same way: one tick short of the limit the block must still be running, and on the limit tick it must be off. The acknowledge and the auto-acknowledge at release are checked against the same boundary.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [2:0] {
    S_OFF, S_WAKE, S_BWAIT, S_SETTLE, S_FLASH, S_HOLD, S_ACTIVE
  } seqState_t;

  typedef enum logic [1:0] {
    G_WAKE, G_SETTLE, G_GAP, G_HOLD
  } stageSel_t;

  typedef struct packed {
    logic      clrStage;
    stageSel_t stageSel;
    logic      wdRun;
    logic      wdLong;
    logic      wdClr;
    logic      latchWake;
    logic      releaseStb;
  } seqStrobe_t;

endpackage

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       anyWake,
  input  logic       battOk,
  input  logic       wdAck,
  input  logic       stageDone,
  input  logic       wdExpire,
  output seqStrobe_t stb,
  output logic       flashOn,
  output logic       mainOn,
  output logic       resetPhase,
  output logic       active
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      S_OFF:    if (anyWake) nextState = S_WAKE;
      S_WAKE:   if (stageDone) nextState = battOk ? S_SETTLE : S_BWAIT;
      S_BWAIT:  if (battOk) nextState = S_SETTLE;
      S_SETTLE: if (stageDone) nextState = S_FLASH;
      S_FLASH:  if (stageDone) nextState = S_HOLD;
      S_HOLD:   if (stageDone) nextState = S_ACTIVE;
      S_ACTIVE: nextState = S_ACTIVE;
      default:  nextState = S_OFF;
    endcase
    if (wdExpire) nextState = S_OFF;
  end

  always_comb begin
    stb = '0;
    unique case (state)
      S_SETTLE: stb.stageSel = G_SETTLE;
      S_FLASH:  stb.stageSel = G_GAP;
      S_HOLD:   stb.stageSel = G_HOLD;
      default:  stb.stageSel = G_WAKE;
    endcase
    stb.clrStage   = (nextState != state);
    stb.wdRun      = (state != S_OFF) && (state != S_WAKE);
    stb.wdLong     = (state != S_ACTIVE);
    stb.wdClr      = (state == S_OFF) || (state == S_WAKE) ||
                     ((state == S_HOLD) && stageDone) ||
                     ((state == S_ACTIVE) && wdAck);
    stb.latchWake  = (state == S_OFF) && anyWake;
    stb.releaseStb = (state == S_HOLD) && stageDone && !wdExpire;
  end

  always_ff @(posedge clk) begin
    if (!sysRstN) state <= S_OFF;
    else          state <= nextState;
  end

  assign flashOn    = (state == S_FLASH) || (state == S_HOLD) || (state == S_ACTIVE);
  assign mainOn     = (state == S_HOLD) || (state == S_ACTIVE);
  assign resetPhase = (state == S_BWAIT) || (state == S_SETTLE) ||
                      (state == S_FLASH) || (state == S_HOLD);
  assign active     = (state == S_ACTIVE);

  // R4: settling is only entered with the battery above cut-off
  p_settle_needs_batt_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    (state == S_SETTLE && $past(state) != S_SETTLE) |-> $past(battOk));

  // R10: no restart from within a sequence
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!sysRstN)
    (state == S_WAKE && $past(state) != S_WAKE) |-> $past(state) == S_OFF);

endmodule

// File: rtl/pwrup_seq_dp.sv
module pwrup_seq_dp
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned WAKE_US      = 20000,
  parameter int unsigned SETTLE_US    = 200000,
  parameter int unsigned GAP_US       = 500,
  parameter int unsigned HOLD_US      = 20000,
  parameter int unsigned WDOG_LONG_US = 2000000,
  parameter int unsigned WDOG_RUN_US  = 500000,
  parameter int unsigned NUM_WAKE     = 4
) (
  input  logic                clk,
  input  logic                sysRstN,
  input  logic                tickUs,
  input  logic [NUM_WAKE-1:0] wakeEvt,
  input  seqStrobe_t          stb,
  output logic                stageDone,
  output logic                wdExpire,
  output logic [NUM_WAKE-1:0] wakeSrc,
  output logic                relIrq
);

  localparam int unsigned STG_A   = (WAKE_US > SETTLE_US) ? WAKE_US : SETTLE_US;
  localparam int unsigned STG_B   = (GAP_US > HOLD_US) ? GAP_US : HOLD_US;
  localparam int unsigned STG_MAX = (STG_A > STG_B) ? STG_A : STG_B;
  localparam int unsigned WD_MAX  = (WDOG_LONG_US > WDOG_RUN_US) ? WDOG_LONG_US : WDOG_RUN_US;
  localparam int unsigned SW      = $clog2(STG_MAX + 1);
  localparam int unsigned WW      = $clog2(WD_MAX + 1);
  localparam logic [SW-1:0] L_WAKE   = SW'(WAKE_US - 1);
  localparam logic [SW-1:0] L_SETTLE = SW'(SETTLE_US - 1);
  localparam logic [SW-1:0] L_GAP    = SW'(GAP_US - 1);
  localparam logic [SW-1:0] L_HOLD   = SW'(HOLD_US - 1);
  localparam logic [WW-1:0] L_WDLONG = WW'(WDOG_LONG_US - 1);
  localparam logic [WW-1:0] L_WDRUN  = WW'(WDOG_RUN_US - 1);

  logic [SW-1:0] stageCnt, stageLim;
  logic [WW-1:0] wdCnt, wdLim;

  always_comb begin
    unique case (stb.stageSel)
      G_SETTLE: stageLim = L_SETTLE;
      G_GAP:    stageLim = L_GAP;
      G_HOLD:   stageLim = L_HOLD;
      default:  stageLim = L_WAKE;
    endcase
  end

  assign stageDone = tickUs && (stageCnt == stageLim);
  assign wdLim     = stb.wdLong ? L_WDLONG : L_WDRUN;
  assign wdExpire  = stb.wdRun && !stb.wdClr && tickUs && (wdCnt == wdLim);

  always_ff @(posedge clk) begin
    if (!sysRstN || stb.clrStage) stageCnt <= '0;
    else if (tickUs && (stageCnt != stageLim)) stageCnt <= stageCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!sysRstN || stb.wdClr) wdCnt <= '0;
    else if (stb.wdRun && tickUs) wdCnt <= wdCnt + 1'b1;
  end

  generate
    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_wake
      always_ff @(posedge clk) begin
        if (!sysRstN)           wakeSrc[i] <= 1'b0;
        else if (stb.latchWake) wakeSrc[i] <= wakeEvt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!sysRstN) relIrq <= 1'b0;
    else          relIrq <= stb.releaseStb;
  end

  // R6: release pulse lasts one cycle
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    relIrq |=> !relIrq);

  // R8: watchdog count never passes the active limit while running
  p_wd_bound_r8: assert property (@(posedge clk) disable iff (!sysRstN)
    stb.wdRun |-> wdCnt <= wdLim);

  // R2: status only changes when a new sequence is latched
  p_wake_hold_r2: assert property (@(posedge clk) disable iff (!sysRstN)
    !$past(stb.latchWake) |-> $stable(wakeSrc));

endmodule

// File: rtl/pwrup_seq_top.sv
module pwrup_seq_top
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned WAKE_US      = 20000,
  parameter int unsigned SETTLE_US    = 200000,
  parameter int unsigned GAP_US       = 500,
  parameter int unsigned HOLD_US      = 20000,
  parameter int unsigned WDOG_LONG_US = 2000000,
  parameter int unsigned WDOG_RUN_US  = 500000,
  parameter int unsigned NUM_MAIN     = 4
) (
  input  logic                clk,
  input  logic                sysRstN,
  input  logic                tickUs,
  input  logic                pwrKeyN,
  input  logic                chargerIn,
  input  logic                battInsert,
  input  logic                rtcAlarm,
  input  logic                battOk,
  input  logic                sleepN,
  input  logic                wdAck,
  output logic                regFlashEn,
  output logic [NUM_MAIN-1:0] regMainEn,
  output logic                oscRegEn,
  output logic                bbResetN,
  output logic [3:0]          wakeSrc,
  output logic                relIrq
);

  localparam int unsigned NUM_WAKE = 4;

  seqStrobe_t          stb;
  logic                stageDone, wdExpire;
  logic                flashOn, mainOn, resetPhase, active;
  logic [NUM_WAKE-1:0] wakeEvt;

  assign wakeEvt = {rtcAlarm, battInsert, chargerIn, !pwrKeyN};

  pwrup_seq_ctrl u_ctrl (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .anyWake    (|wakeEvt),
    .battOk     (battOk),
    .wdAck      (wdAck),
    .stageDone  (stageDone),
    .wdExpire   (wdExpire),
    .stb        (stb),
    .flashOn    (flashOn),
    .mainOn     (mainOn),
    .resetPhase (resetPhase),
    .active     (active)
  );

  pwrup_seq_dp #(
    .WAKE_US      (WAKE_US),
    .SETTLE_US    (SETTLE_US),
    .GAP_US       (GAP_US),
    .HOLD_US      (HOLD_US),
    .WDOG_LONG_US (WDOG_LONG_US),
    .WDOG_RUN_US  (WDOG_RUN_US),
    .NUM_WAKE     (NUM_WAKE)
  ) u_dp (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .tickUs    (tickUs),
    .wakeEvt   (wakeEvt),
    .stb       (stb),
    .stageDone (stageDone),
    .wdExpire  (wdExpire),
    .wakeSrc   (wakeSrc),
    .relIrq    (relIrq)
  );

  assign regFlashEn = flashOn;
  assign regMainEn  = {NUM_MAIN{mainOn}};
  assign oscRegEn   = resetPhase || (active && sleepN);
  assign bbResetN   = active;

  // R6: reset only released with every supply on
  p_release_supplies_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    bbResetN |-> (regFlashEn && (&regMainEn)));

  // R6: release edge and interrupt pulse coincide
  p_irq_at_rise_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(bbResetN) |-> relIrq);

  // R5: main supplies never rise ahead of the flash supply
  p_main_after_flash_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(regMainEn[0]) |-> $past(regFlashEn));

  // R7: oscillator supply forced on while supplies are up in reset
  p_osc_forced_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    (!bbResetN && regFlashEn) |-> oscRegEn);

  // R10: status stays put while running
  p_status_stable_r10: assert property (@(posedge clk) disable iff (!sysRstN)
    bbResetN |-> $stable(wakeSrc));

endmodule

// File: tb/tb_pwrup_seq_top.sv
module tb_pwrup_seq_top;

  localparam int unsigned P_WAKE = 4;
  localparam int unsigned P_SET  = 6;
  localparam int unsigned P_GAP  = 2;
  localparam int unsigned P_HOLD = 5;
  localparam int unsigned P_WDL  = 40;
  localparam int unsigned P_WDR  = 10;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic tickUs = 1'b0, pwrKeyN = 1'b1, chargerIn = 1'b0, battInsert = 1'b0;
  logic rtcAlarm = 1'b0, battOk = 1'b0, sleepN = 1'b0, wdAck = 1'b0;
  logic regFlashEn, oscRegEn, bbResetN, relIrq;
  logic [3:0] regMainEn, wakeSrc;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwrup_seq_top #(
    .WAKE_US(P_WAKE), .SETTLE_US(P_SET), .GAP_US(P_GAP), .HOLD_US(P_HOLD),
    .WDOG_LONG_US(P_WDL), .WDOG_RUN_US(P_WDR), .NUM_MAIN(4)
  ) dut (
    .clk(clk), .sysRstN(sysRstN), .tickUs(tickUs), .pwrKeyN(pwrKeyN),
    .chargerIn(chargerIn), .battInsert(battInsert), .rtcAlarm(rtcAlarm),
    .battOk(battOk), .sleepN(sleepN), .wdAck(wdAck),
    .regFlashEn(regFlashEn), .regMainEn(regMainEn), .oscRegEn(oscRegEn),
    .bbResetN(bbResetN), .wakeSrc(wakeSrc), .relIrq(relIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packs outputs: {bbResetN, oscRegEn, regFlashEn, regMainEn}
  function automatic logic [6:0] outs();
    return {bbResetN, oscRegEn, regFlashEn, regMainEn};
  endfunction

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickUs = 1'b1;
      @(negedge clk) tickUs = 1'b0;
    end
  endtask

  task automatic wake(input logic [3:0] m);
    @(negedge clk);
    pwrKeyN = !m[0]; chargerIn = m[1]; battInsert = m[2]; rtcAlarm = m[3];
    @(negedge clk);
    pwrKeyN = 1'b1; chargerIn = 1'b0; battInsert = 1'b0; rtcAlarm = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 outputs in reset", {outs(), relIrq, wakeSrc}, 32'h0);
    sysRstN = 1'b1;
    repeat (3) @(negedge clk);
    tickN(2);
    chk("R1 idle after reset", {outs(), relIrq, wakeSrc}, 32'h0);
  endtask

  task automatic t_keySeq();
    battOk = 1'b1; sleepN = 1'b0;
    wake(4'b0001);
    chk("R2 key latched", wakeSrc, 4'b0001);
    tickN(P_WAKE - 1);
    chk("R3 nothing on in wake delay", outs(), 7'b0);
    tickN(1);
    chk("R7 osc forced with sleep low", outs(), 7'b0100000);
    tickN(P_SET - 1);
    chk("R4 flash off before settle end", regFlashEn, 1'b0);
    tickN(1);
    chk("R4 flash on at settle end", outs(), 7'b0110000);
    tickN(P_GAP - 1);
    chk("R5 main off before gap end", regMainEn, 4'h0);
    tickN(1);
    chk("R5 main on together", outs(), 7'b0111111);
    tickN(P_HOLD - 1);
    chk("R6 reset held", bbResetN, 1'b0);
    tickN(1);
    chk("R6 reset released", {bbResetN, relIrq}, 2'b11);
    chk("R7 osc follows sleep low", oscRegEn, 1'b0);
    @(negedge clk);
    chk("R6 irq one cycle", relIrq, 1'b0);
    sleepN = 1'b1;
    @(negedge clk);
    chk("R7 osc follows sleep high", oscRegEn, 1'b1);
    wake(4'b1000);
    @(negedge clk);
    chk("R10 event ignored when running", {bbResetN, wakeSrc}, 5'b10001);
    tickN(P_WDR - 1);
    chk("R9 auto-ack at release", bbResetN, 1'b1);
    @(negedge clk) wdAck = 1'b1;
    @(negedge clk) wdAck = 1'b0;
    tickN(P_WDR - 1);
    chk("R9 ack restarts count", bbResetN, 1'b1);
    tickN(1);
    chk("R9 expiry powers off", outs(), 7'b0);
  endtask

  task automatic t_battWait();
    battOk = 1'b0; sleepN = 1'b0;
    wake(4'b1010);
    chk("R2 two sources latched", wakeSrc, 4'b1010);
    tickN(P_WAKE);
    chk("R4 waiting with osc only", outs(), 7'b0100000);
    wake(4'b0001);
    chk("R10 status kept during sequence", wakeSrc, 4'b1010);
    tickN(20);
    chk("R4 no flash while battery low", regFlashEn, 1'b0);
    @(negedge clk) battOk = 1'b1;
    @(negedge clk);
    tickN(P_SET - 1);
    chk("R4 flash off one tick early", regFlashEn, 1'b0);
    tickN(1);
    chk("R4 flash on after battery ok", regFlashEn, 1'b1);
    tickN(P_GAP + P_HOLD);
    chk("R6 release after wait", bbResetN, 1'b1);
    tickN(P_WDR);
    chk("R9 expiry without ack", outs(), 7'b0);
  endtask

  task automatic t_wdReset();
    battOk = 1'b0;
    wake(4'b0100);
    chk("R2 status replaced", wakeSrc, 4'b0100);
    tickN(P_WAKE);
    tickN(P_WDL - 1);
    chk("R8 still in reset phase", outs(), 7'b0100000);
    tickN(1);
    chk("R8 long watchdog expires", outs(), 7'b0);
    battOk = 1'b1;
    tickN(3);
    chk("R8 stays off after expiry", {outs(), relIrq}, 8'h0);
  endtask

  initial begin
    t_reset();
    t_keySeq();
    t_battWait();
    t_wdReset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule